// File: doc/BRIEF.md
# Serial Write Port with CRC-8 Frame Check

This block is the receive side of a serial-peripheral slave port for a register-programmed device. Frames arrive on a data-in pin, one bit per rising edge of the serial clock, most significant bit first, while the active-low chip select is held low. The frame is judged when chip select returns high. With integrity checking off, a frame is 24 bits long and all 24 bits form the write word. With checking on, a frame is 32 bits long: the upper 24 bits are the write word and the low byte is a CRC-8 that the host computes over them. The generator polynomial is x^8 + x^2 + x + 1 (0x07). The remainder starts from zero in every frame and must be zero over all 32 bits.

A clean frame goes out as one write on a valid/ready stream. A frame whose bit count does not match the current mode is dropped without any other effect. A frame whose remainder is nonzero is dropped as well. It also sets a sticky fault flag and pulls the active-low alarm output low. The fault clears only on a software clear pulse, on a power-down request, or while checking is disabled. The write stream obeys back-pressure as follows: once `wr_valid` rises, `wr_valid` and `wr_data` hold until a cycle with `wr_ready` high. Any clean frame that completes while a write is still outstanding is lost, so the host must not start a new frame before the previous write has been accepted.

For readback, the system side hands in a 24-bit word on a second valid/ready stream, but only between frames. The block shifts that word out on the data-out pin during the next frame, changing the pin on falling serial-clock edges. In checking mode, the word is followed by its own CRC-8, which makes a 32-bit frame. The serial pins are sampled by the system clock, which must run at least eight times faster than the serial clock.

Top module: `spi_crc_frontend`

## Requirements
- R1: Right after reset, `wr_valid` is 0, `crc_fault` is 0, `alarm_n` is 1, `miso` is 0 and `rd_ready` is 1.
- R2: With `crc_en` = 0, a 24-bit frame produces one write whose `wr_data` bit 23 is the first bit received and bit 0 is the last.
- R3: With `crc_en` = 1, a 32-bit frame whose low 8 bits are the CRC-8 (poly 0x07, init 0x00, MSB first, no reflection) of its upper 24 bits produces one write carrying those upper 24 bits (frame bits 31:8).
- R4: With `crc_en` = 1, a 32-bit frame whose remainder over all 32 bits is nonzero produces no write, sets `crc_fault` to 1 and drives `alarm_n` to 0.
- R5: `crc_fault` is sticky. Later clean frames are still written, and the fault stays set until it is cleared.
- R6: `crc_fault` returns to 0 one cycle after any of the following: a `sw_clear` pulse, `pwr_dn` high, or `crc_en` low. `alarm_n` then returns to 1.
- R7: A frame with the wrong bit count for the current mode (not 24 when `crc_en` = 0, not 32 when `crc_en` = 1) produces no write and leaves `crc_fault` unchanged.
- R8: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid` and `wr_data` stay unchanged. A clean frame that completes during this time is dropped, and the held word is the one delivered.
- R9: With `crc_en` = 1, a readback word accepted on `rd_valid`/`rd_ready` appears on `miso` during the next frame as 32 bits, MSB first: the 24-bit word followed by its CRC-8. With `crc_en` = 0, only the 24 bits are sent.
- R10: `rd_ready` is 0 while a frame is in progress (chip select low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial readback data to the host |
| crc_en | input | 1 | 1 selects 32-bit frames with CRC check |
| sw_clear | input | 1 | One-cycle pulse that clears the fault |
| pwr_dn | input | 1 | Power-down request; clears the fault |
| wr_valid | output | 1 | A clean write word is available |
| wr_ready | input | 1 | Sink accepts the write word |
| wr_data | output | 24 | Write word |
| rd_valid | input | 1 | Readback word offered |
| rd_ready | output | 1 | Readback word can be loaded (between frames) |
| rd_data | input | 24 | Readback word |
| crc_fault | output | 1 | Sticky CRC fault flag |
| alarm_n | output | 1 | Active-low alarm, low while the fault is set |

## Verification
The hardest case to reach from the ports is a clean frame arriving while an earlier write is still held by back-pressure. This needs the sink stalled across an entire serial frame. The bench holds `wr_ready` low, sends two different clean frames, checks that the first word stays on `wr_data`, and then releases the sink to see exactly one write of the first word. The sticky fault is driven the same way: a corrupted frame is followed by a clean one, and each clear path is then exercised on its own.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;
  localparam int PAYLOAD_W = 24;
  localparam int CRC_W     = 8;
  localparam int FRAME_W   = PAYLOAD_W + CRC_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

  // One serial step of the remainder division, MSB first.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  function automatic logic [CRC_W-1:0] crc_of_word(input logic [PAYLOAD_W-1:0] d);
    logic [CRC_W-1:0] c;
    c = '0;
    for (int i = PAYLOAD_W - 1; i >= 0; i--) c = crc_step(c, d[i]);
    return c;
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_begin,
  output logic cs_end,
  output logic cs_act,
  output logic mosi_s
);
  // bit 0 sclk, bit 1 cs_n, bit 2 mosi; index STAGES holds the previous value
  localparam logic [2:0] IDLE = 3'b010;
  logic [STAGES:0][2:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= STAGES; i++) pipe[i] <= IDLE;
    end else begin
      pipe[0] <= {mosi, cs_n, sclk};
      for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign sclk_rise = pipe[STAGES-1][0] & ~pipe[STAGES][0];
  assign sclk_fall = ~pipe[STAGES-1][0] & pipe[STAGES][0];
  assign cs_begin  = ~pipe[STAGES-1][1] & pipe[STAGES][1];
  assign cs_end    = pipe[STAGES-1][1] & ~pipe[STAGES][1];
  assign cs_act    = ~pipe[STAGES-1][1];
  assign mosi_s    = pipe[STAGES-1][2];
endmodule

// File: rtl/spi_crc8_acc.sv
module spi_crc8_acc
  import spi_crc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] rem
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rem <= '0;
    else if (clr) rem <= '0;
    else if (en)  rem <= crc_step(rem, din);
  end
endmodule

// File: rtl/spi_readback_tx.sv
module spi_readback_tx
  import spi_crc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [PAYLOAD_W-1:0] word,
  input  logic                 with_crc,
  input  logic                 shift,
  output logic                 sdo
);
  logic [FRAME_W-1:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tx_sh <= '0;
    else if (load)  tx_sh <= {word, with_crc ? crc_of_word(word) : {CRC_W{1'b0}}};
    else if (shift) tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
  end

  assign sdo = tx_sh[FRAME_W-1];
endmodule

// File: rtl/spi_crc_frontend.sv
module spi_crc_frontend
  import spi_crc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk,
  input  logic                 cs_n,
  input  logic                 mosi,
  output logic                 miso,
  input  logic                 crc_en,
  input  logic                 sw_clear,
  input  logic                 pwr_dn,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [PAYLOAD_W-1:0] wr_data,
  input  logic                 rd_valid,
  output logic                 rd_ready,
  input  logic [PAYLOAD_W-1:0] rd_data,
  output logic                 crc_fault,
  output logic                 alarm_n
);
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic sclk_rise, sclk_fall, cs_begin, cs_end, cs_act, mosi_s;
  logic [FRAME_W-1:0] rx_sh;
  logic [CNT_W-1:0]   bit_cnt;
  logic [CRC_W-1:0]   rem;
  logic               len_ok, crc_bad, frame_ok;
  logic [PAYLOAD_W-1:0] payload;

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_begin(cs_begin),
    .cs_end(cs_end), .cs_act(cs_act), .mosi_s(mosi_s)
  );

  // Receive shifter and saturating bit counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh   <= '0;
      bit_cnt <= '0;
    end else if (cs_begin) begin
      rx_sh   <= '0;
      bit_cnt <= '0;
    end else if (cs_act && sclk_rise) begin
      rx_sh <= {rx_sh[FRAME_W-2:0], mosi_s};
      if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  spi_crc8_acc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(cs_begin),
    .en(cs_act && sclk_rise), .din(mosi_s), .rem(rem)
  );

  assign len_ok   = bit_cnt == (crc_en ? CNT_W'(FRAME_W) : CNT_W'(PAYLOAD_W));
  assign crc_bad  = crc_en && len_ok && (rem != '0);
  assign frame_ok = len_ok && !crc_bad;
  assign payload  = crc_en ? rx_sh[FRAME_W-1:CRC_W] : rx_sh[PAYLOAD_W-1:0];

  // Write stream: a held word blocks newer frames
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_data  <= '0;
    end else if (!wr_valid) begin
      if (cs_end && frame_ok) begin
        wr_valid <= 1'b1;
        wr_data  <= payload;
      end
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  // Sticky fault, clear sources win
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             crc_fault <= 1'b0;
    else if (sw_clear || pwr_dn || !crc_en) crc_fault <= 1'b0;
    else if (cs_end && crc_bad)             crc_fault <= 1'b1;
  end

  assign alarm_n  = ~crc_fault;
  assign rd_ready = ~cs_act;

  spi_readback_tx u_tx (
    .clk(clk), .rst_n(rst_n), .load(rd_valid && rd_ready), .word(rd_data),
    .with_crc(crc_en), .shift(cs_act && sclk_fall), .sdo(miso)
  );
endmodule

// File: rtl/spi_crc_frontend_chk.sv
module spi_crc_frontend_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        crc_en,
  input logic        sw_clear,
  input logic        pwr_dn,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [23:0] wr_data,
  input logic        crc_fault,
  input logic        alarm_n
);
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data)); // R8
  AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clear || pwr_dn || !crc_en |=> !crc_fault); // R6
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    crc_fault && crc_en && !sw_clear && !pwr_dn |=> crc_fault); // R5
  AST_NO_WRITE_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_fault) |-> !$rose(wr_valid)); // R4
  AST_ALARM_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_fault) |-> !alarm_n); // R4
endmodule

bind spi_crc_frontend spi_crc_frontend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .sw_clear(sw_clear), .pwr_dn(pwr_dn),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
  .crc_fault(crc_fault), .alarm_n(alarm_n)
);

// File: tb/tb_spi_crc_frontend.sv
module tb_spi_crc_frontend;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic crc_en = 1'b0, sw_clear = 1'b0, pwr_dn = 1'b0;
  logic wr_valid, wr_ready = 1'b1;
  logic [23:0] wr_data;
  logic rd_valid = 1'b0, rd_ready;
  logic [23:0] rd_data = '0;
  logic crc_fault, alarm_n;

  int vectors = 0, miscompares = 0, wr_cnt = 0;
  logic [23:0] wr_last = '0;
  logic [31:0] rx = '0;
  logic rd_ready_mid = 1'b1;
  bit done = 0;

  always #2 clk = ~clk;

  spi_crc_frontend dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .crc_en(crc_en), .sw_clear(sw_clear), .pwr_dn(pwr_dn),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .crc_fault(crc_fault), .alarm_n(alarm_n)
  );

  always @(posedge clk) if (rst_n && wr_valid && wr_ready) begin
    wr_cnt  <= wr_cnt + 1;
    wr_last <= wr_data;
  end

  function automatic logic [7:0] ref_crc(input logic [23:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 23; i >= 0; i--) begin
      logic top = c[7] ^ d[i];
      c = c << 1;
      if (top) c = c ^ 8'h07;
    end
    return c;
  endfunction

  task automatic wait_clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [31:0] w, input int n);
    cs_n = 1'b0;
    wait_clks(8);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = w[i];
      wait_clks(8);
      rx = {rx[30:0], miso};
      if (i == n - 4) rd_ready_mid = rd_ready;
      sclk = 1'b1;
      wait_clks(8);
      sclk = 1'b0;
    end
    wait_clks(8);
    cs_n = 1'b1;
    wait_clks(10);
  endtask

  task automatic t_reset;
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 crc_fault", crc_fault, 0);
    chk("R1 alarm_n", alarm_n, 1);
    chk("R1 miso", miso, 0);
    chk("R1 rd_ready", rd_ready, 1);
  endtask

  task automatic t_plain24;
    int c0 = wr_cnt;
    crc_en = 1'b0;
    send_frame({8'h00, 24'h5A17C3}, 24);
    chk("R2 count", wr_cnt - c0, 1);
    chk("R2 data", wr_last, 24'h5A17C3);
    send_frame({8'h00, 24'h800001}, 24);
    chk("R2 data order", wr_last, 24'h800001);
  endtask

  task automatic t_crc_good;
    logic [23:0] d = 24'h3C9E01;
    int c0;
    crc_en = 1'b1;
    wait_clks(2);
    c0 = wr_cnt;
    send_frame({d, ref_crc(d)}, 32);
    chk("R3 count", wr_cnt - c0, 1);
    chk("R3 data", wr_last, d);
    chk("R3 no fault", crc_fault, 0);
  endtask

  task automatic t_crc_bad_sticky;
    logic [23:0] d = 24'h00F0AA;
    int c0 = wr_cnt;
    send_frame({d, ref_crc(d) ^ 8'h10}, 32);
    chk("R4 no write", wr_cnt - c0, 0);
    chk("R4 fault", crc_fault, 1);
    chk("R4 alarm_n", alarm_n, 0);
    send_frame({d ^ 24'h000100, ref_crc(d)}, 32);
    chk("R4 payload flip no write", wr_cnt - c0, 0);
    d = 24'h123456;
    send_frame({d, ref_crc(d)}, 32);
    chk("R5 clean write after fault", wr_cnt - c0, 1);
    chk("R5 clean data", wr_last, d);
    chk("R5 fault stays", crc_fault, 1);
  endtask

  task automatic inject_fault;
    send_frame({24'hABCDEF, ref_crc(24'hABCDEF) ^ 8'h01}, 32);
  endtask

  task automatic t_clears;
    inject_fault();
    chk("R6 fault set pre-clear", crc_fault, 1);
    sw_clear = 1'b1; wait_clks(1); sw_clear = 1'b0; wait_clks(1);
    chk("R6 sw_clear", crc_fault, 0);
    chk("R6 alarm_n release", alarm_n, 1);
    inject_fault();
    pwr_dn = 1'b1; wait_clks(1); pwr_dn = 1'b0; wait_clks(1);
    chk("R6 pwr_dn", crc_fault, 0);
    inject_fault();
    crc_en = 1'b0; wait_clks(2); crc_en = 1'b1; wait_clks(1);
    chk("R6 crc_en low", crc_fault, 0);
  endtask

  task automatic t_bad_length;
    logic [23:0] d = 24'h777777;
    int c0 = wr_cnt;
    crc_en = 1'b1; wait_clks(1);
    send_frame({8'h00, d}, 24);
    chk("R7 24 bits in crc mode", wr_cnt - c0, 0);
    chk("R7 no fault", crc_fault, 0);
    send_frame({d, ref_crc(d)}, 31);
    chk("R7 31 bits", wr_cnt - c0, 0);
    crc_en = 1'b0; wait_clks(1);
    send_frame({d, ref_crc(d)}, 32);
    chk("R7 32 bits plain mode", wr_cnt - c0, 0);
  endtask

  task automatic t_backpressure;
    int c0 = wr_cnt;
    crc_en = 1'b0;
    wr_ready = 1'b0;
    send_frame({8'h00, 24'hC0FFEE}, 24);
    chk("R8 valid held", wr_valid, 1);
    chk("R8 data", wr_data, 24'hC0FFEE);
    send_frame({8'h00, 24'h0BADF0}, 24);
    chk("R8 data kept", wr_data, 24'hC0FFEE);
    wr_ready = 1'b1;
    wait_clks(3);
    chk("R8 one write", wr_cnt - c0, 1);
    chk("R8 delivered word", wr_last, 24'hC0FFEE);
    chk("R8 valid drops", wr_valid, 0);
  endtask

  task automatic t_readback;
    logic [23:0] d = 24'hA5C31E;
    crc_en = 1'b1; wait_clks(1);
    rd_data = d; rd_valid = 1'b1; wait_clks(1); rd_valid = 1'b0;
    send_frame(32'h0, 32);
    chk("R9 crc readback", rx, {d, ref_crc(d)});
    chk("R10 rd_ready busy", rd_ready_mid, 0);
    chk("R10 rd_ready idle", rd_ready, 1);
    crc_en = 1'b0; wait_clks(1);
    d = 24'h9104E2;
    rd_data = d; rd_valid = 1'b1; wait_clks(1); rd_valid = 1'b0;
    send_frame(32'h0, 24);
    chk("R9 plain readback", rx[23:0], d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(2);
    t_reset();
    t_plain24();
    t_crc_good();
    t_crc_bad_sticky();
    t_clears();
    t_bad_length();
    t_backpressure();
    t_readback();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule